// File: doc/BRIEF.md
# Two-Way Doorbell Mailbox

This block connects two processors, called side A and side B, through a pair of one-way mailboxes. Each mailbox holds a bank of message words and a doorbell word. The sending side fills the words and then posts a doorbell with its trigger bit set. That trigger is the receiving side's interrupt. The receiver reads the doorbell to confirm that the interrupt belongs to this mailbox, then reads the payload. It hands the mailbox back by writing the doorbell with the trigger bit at zero.

Each side has a plain register bus with a combinational read port. It also has a valid/ready submission stream into a small in-order queue. The stream loads payload words into the bank one after another. Its last beat becomes the doorbell and always raises the trigger. `tx_ready` goes low only when the queue is full, and a beat transfers on a clock edge where `tx_valid` and `tx_ready` are both high. The queue stops draining while the outbound trigger is set, so fragments reach the peer one at a time, in the order they were submitted.

Top module: `doorbell_mailbox`

## Requirements
- R1: After reset, both interrupts are low, both `busy` flags are low, `tx_ready` is high, and every doorbell and message word reads 0.
- R2: Register map on each side (address width 6): addresses 0 to 31 are message words. A write goes to the outbound bank and a read returns the inbound bank. Address 32 is the inbound doorbell, address 33 is the outbound doorbell, and every other address reads 0 and ignores writes.
- R3: The doorbell keeps only these fields: fragment length in bits 6:0, protocol code in bits 13:10, management command in bits 19:16 and trigger in bit 31. Every other bit reads 0, whatever was written.
- R4: The management command field is kept only when the protocol code equals 1. For any other protocol code it reads 0.
- R5: Writing the outbound doorbell with bit 31 set raises the peer's interrupt on the next clock. The peer then reads the same doorbell value and the message words that were written.
- R6: A receiver write to address 32 with bit 31 at 0 drops the interrupt on the next clock. The other doorbell fields keep their values. A write with bit 31 at 1 has no effect.
- R7: A sender bus write to addresses 0 to 33 is dropped while the outbound trigger is set, or while a queued fragment is pending. The side's `busy` output then pulses high for one cycle after that write.
- R8: On the stream, each beat with `tx_last` low stores the next message word, starting at word 0. The beat with `tx_last` high loads the doorbell with its fields scrubbed as in R3 and R4 and with the trigger forced to 1. `tx_ready` is low exactly when the queue (depth 4) is full.
- R9: A queued fragment is not presented until the previous trigger has been cleared. The peer interrupt stays low until that fragment's last beat has drained.
- R10: Stream payload beats after the 32nd word of a fragment are discarded, so word 31 keeps the 32nd payload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_sel | input | 1 | Side A register access strobe |
| a_we | input | 1 | Side A write enable |
| a_addr | input | 6 | Side A word address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data (combinational) |
| a_busy | output | 1 | Side A dropped-write pulse |
| a_irq | output | 1 | Interrupt toward side A |
| a_tx_valid | input | 1 | Side A stream beat valid |
| a_tx_ready | output | 1 | Side A stream can accept |
| a_tx_data | input | 32 | Side A stream beat data |
| a_tx_last | input | 1 | Side A beat is the doorbell |
| b_sel | input | 1 | Side B register access strobe |
| b_we | input | 1 | Side B write enable |
| b_addr | input | 6 | Side B word address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data (combinational) |
| b_busy | output | 1 | Side B dropped-write pulse |
| b_irq | output | 1 | Interrupt toward side B |
| b_tx_valid | input | 1 | Side B stream beat valid |
| b_tx_ready | output | 1 | Side B stream can accept |
| b_tx_data | input | 32 | Side B stream beat data |
| b_tx_last | input | 1 | Side B beat is the doorbell |

## Verification
The bench sets every reserved doorbell bit and uses protocol codes both equal to 1 and not equal to 1. A faulty field mask or command gate would show up as stray bits or a leaked command. It writes into a mailbox whose trigger is still set and then reads the peer bank after the clear. A design that let the write through would show the new word there, or no busy pulse. It stacks a second fragment behind an unacknowledged one until the queue is full. A design that drained early would overwrite the presented doorbell or raise the interrupt before the last beat. Finally, a 33-word payload probes word 31, where an index that wraps or overruns would leave the wrong value.

// File: rtl/dbmx_pkg.sv
package dbmx_pkg;
  localparam int WORD_W = 32;
  localparam int DB_TRIG = 31;
  // bits 6:0 length, 13:10 protocol, 19:16 command, 31 trigger
  localparam logic [WORD_W-1:0] DB_KEEP = 32'h800F_3C7F;
  localparam logic [WORD_W-1:0] DB_CMD_BITS = 32'h000F_0000;

  function automatic logic [WORD_W-1:0] db_scrub(input logic [WORD_W-1:0] v,
                                                 input logic [3:0] mgmt);
    logic [WORD_W-1:0] r;
    r = v & DB_KEEP;
    if (v[13:10] != mgmt) r = r & ~DB_CMD_BITS;
    return r;
  endfunction
endpackage

// File: rtl/dbmx_fifo.sv
module dbmx_fifo #(
  parameter int W = 33,
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  input  logic         pop,
  output logic         nonempty,
  output logic [W-1:0] head
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full     = (cnt_q == CW'(DEPTH));
  assign nonempty = (cnt_q != '0);
  assign head     = mem[rp_q];
  assign do_push  = push && !full;
  assign do_pop   = pop && nonempty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + PW'(1);
      if (do_pop)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + PW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/dbmx_lane.sv
module dbmx_lane import dbmx_pkg::*; #(
  parameter int MSG_WORDS = 32,
  parameter int QDEPTH = 4,
  parameter logic [3:0] MGMT_PROTO = 4'd1,
  localparam int IDX_W = $clog2(MSG_WORDS),
  localparam int CNT_W = $clog2(MSG_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  // sender register path
  input  logic              snd_wr,
  input  logic              snd_db,
  input  logic [IDX_W-1:0]  snd_idx,
  input  logic [WORD_W-1:0] snd_wdata,
  // sender stream
  input  logic              q_valid,
  output logic              q_ready,
  input  logic [WORD_W-1:0] q_data,
  input  logic              q_last,
  // receiver
  input  logic              rcv_clr,
  input  logic [IDX_W-1:0]  rcv_idx,
  output logic [WORD_W-1:0] rcv_word,
  output logic [WORD_W-1:0] db,
  output logic              busy
);
  logic [WORD_W-1:0] bank [MSG_WORDS];
  logic [WORD_W-1:0] db_q;
  logic [CNT_W-1:0]  fill_q;
  logic              busy_q;
  logic              full, h_valid, trig, pop, open;
  logic [WORD_W:0]   head;
  logic              bank_we;
  logic [IDX_W-1:0]  bank_wi;
  logic [WORD_W-1:0] bank_wd;

  dbmx_fifo #(.W(WORD_W + 1), .DEPTH(QDEPTH)) u_q (
    .clk(clk), .rst_n(rst_n),
    .push(q_valid), .push_data({q_last, q_data}), .full(full),
    .pop(pop), .nonempty(h_valid), .head(head)
  );

  assign q_ready = !full;
  assign trig    = db_q[DB_TRIG];
  assign pop     = h_valid && !trig;
  assign open    = !trig && !h_valid && (fill_q == '0);

  always_comb begin
    bank_we = 1'b0;
    bank_wi = snd_idx;
    bank_wd = snd_wdata;
    if (pop) begin
      if (!head[WORD_W] && fill_q < CNT_W'(MSG_WORDS)) begin
        bank_we = 1'b1;
        bank_wi = fill_q[IDX_W-1:0];
        bank_wd = head[WORD_W-1:0];
      end
    end else if (snd_wr && open && !snd_db) begin
      bank_we = 1'b1;
    end
  end

  for (genvar g = 0; g < MSG_WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                               bank[g] <= '0;
      else if (bank_we && bank_wi == IDX_W'(g)) bank[g] <= bank_wd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      db_q   <= '0;
      fill_q <= '0;
      busy_q <= 1'b0;
    end else begin
      busy_q <= snd_wr && !open;
      if (pop) begin
        if (head[WORD_W]) begin
          db_q   <= db_scrub(head[WORD_W-1:0], MGMT_PROTO) | (WORD_W'(1) << DB_TRIG);
          fill_q <= '0;
        end else if (fill_q < CNT_W'(MSG_WORDS)) begin
          fill_q <= fill_q + CNT_W'(1);
        end
      end else if (snd_wr && open && snd_db) begin
        db_q <= db_scrub(snd_wdata, MGMT_PROTO);
      end
      if (rcv_clr && trig) db_q[DB_TRIG] <= 1'b0;
    end
  end

  assign rcv_word = bank[rcv_idx];
  assign db       = db_q;
  assign busy     = busy_q;
endmodule

// File: rtl/doorbell_mailbox.sv
module doorbell_mailbox import dbmx_pkg::*; #(
  parameter int MSG_WORDS = 32,
  parameter int QDEPTH = 4,
  parameter logic [3:0] MGMT_PROTO = 4'd1,
  localparam int ADDR_W = $clog2(MSG_WORDS) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_sel,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [WORD_W-1:0] a_wdata,
  output logic [WORD_W-1:0] a_rdata,
  output logic              a_busy,
  output logic              a_irq,
  input  logic              a_tx_valid,
  output logic              a_tx_ready,
  input  logic [WORD_W-1:0] a_tx_data,
  input  logic              a_tx_last,
  input  logic              b_sel,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [WORD_W-1:0] b_wdata,
  output logic [WORD_W-1:0] b_rdata,
  output logic              b_busy,
  output logic              b_irq,
  input  logic              b_tx_valid,
  output logic              b_tx_ready,
  input  logic [WORD_W-1:0] b_tx_data,
  input  logic              b_tx_last
);
  localparam int IDX_W = ADDR_W - 1;
  localparam logic [ADDR_W-1:0] IN_DB  = ADDR_W'(MSG_WORDS);
  localparam logic [ADDR_W-1:0] OUT_DB = ADDR_W'(MSG_WORDS + 1);

  logic              sel [2], we [2], txv [2], txr [2], txl [2], bsy [2];
  logic [ADDR_W-1:0] addr [2];
  logic [WORD_W-1:0] wd [2], txd [2], rd [2], dbv [2], inw [2];

  assign sel[0] = a_sel;      assign sel[1] = b_sel;
  assign we[0] = a_we;        assign we[1] = b_we;
  assign addr[0] = a_addr;    assign addr[1] = b_addr;
  assign wd[0] = a_wdata;     assign wd[1] = b_wdata;
  assign txv[0] = a_tx_valid; assign txv[1] = b_tx_valid;
  assign txd[0] = a_tx_data;  assign txd[1] = b_tx_data;
  assign txl[0] = a_tx_last;  assign txl[1] = b_tx_last;
  assign a_rdata = rd[0];     assign b_rdata = rd[1];
  assign a_busy = bsy[0];     assign b_busy = bsy[1];
  assign a_tx_ready = txr[0]; assign b_tx_ready = txr[1];
  assign a_irq = dbv[1][DB_TRIG];
  assign b_irq = dbv[0][DB_TRIG];

  // lane i carries side i to side 1-i
  for (genvar i = 0; i < 2; i++) begin : g_lane
    localparam int J = 1 - i;
    logic snd_wr, snd_db, rcv_clr;
    assign snd_db  = (addr[i] == OUT_DB);
    assign snd_wr  = sel[i] && we[i] && ((addr[i] < IN_DB) || snd_db);
    assign rcv_clr = sel[J] && we[J] && (addr[J] == IN_DB) && !wd[J][DB_TRIG];

    dbmx_lane #(.MSG_WORDS(MSG_WORDS), .QDEPTH(QDEPTH), .MGMT_PROTO(MGMT_PROTO)) u_lane (
      .clk(clk), .rst_n(rst_n),
      .snd_wr(snd_wr), .snd_db(snd_db), .snd_idx(addr[i][IDX_W-1:0]), .snd_wdata(wd[i]),
      .q_valid(txv[i]), .q_ready(txr[i]), .q_data(txd[i]), .q_last(txl[i]),
      .rcv_clr(rcv_clr), .rcv_idx(addr[J][IDX_W-1:0]), .rcv_word(inw[J]),
      .db(dbv[i]), .busy(bsy[i])
    );
  end

  for (genvar k = 0; k < 2; k++) begin : g_rd
    always_comb begin
      if (addr[k] < IN_DB)        rd[k] = inw[k];
      else if (addr[k] == IN_DB)  rd[k] = dbv[1-k];
      else if (addr[k] == OUT_DB) rd[k] = dbv[k];
      else                        rd[k] = '0;
    end
  end
endmodule

// File: rtl/doorbell_mailbox_chk.sv
module doorbell_mailbox_chk #(
  parameter int ADDR_W = 6,
  parameter int MSG_WORDS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_sel,
  input logic              a_we,
  input logic [ADDR_W-1:0] a_addr,
  input logic [31:0]       a_wdata,
  input logic [31:0]       a_rdata,
  input logic              a_busy,
  input logic              a_irq,
  input logic              b_sel,
  input logic              b_we,
  input logic [ADDR_W-1:0] b_addr,
  input logic [31:0]       b_wdata,
  input logic [31:0]       b_rdata,
  input logic              b_busy,
  input logic              b_irq
);
  localparam logic [31:0] KEEP = 32'h800F_3C7F;
  localparam logic [ADDR_W-1:0] IN_DB  = ADDR_W'(MSG_WORDS);
  localparam logic [ADDR_W-1:0] OUT_DB = ADDR_W'(MSG_WORDS + 1);

  logic a_clr, b_clr;
  assign a_clr = a_sel && a_we && a_addr == IN_DB && !a_wdata[31];
  assign b_clr = b_sel && b_we && b_addr == IN_DB && !b_wdata[31];

  assert_reserved_zero_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_sel && !a_we && (a_addr == IN_DB || a_addr == OUT_DB)) |-> ((a_rdata & ~KEEP) == 32'h0));
  assert_reserved_zero_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (b_sel && !b_we && (b_addr == IN_DB || b_addr == OUT_DB)) |-> ((b_rdata & ~KEEP) == 32'h0));
  assert_clear_drops_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    b_clr |=> !b_irq);
  assert_irq_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (b_irq && !b_clr) |=> b_irq);
  assert_irq_holds_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_irq && !a_clr) |=> a_irq);
  assert_busy_on_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (a_sel && a_we && a_addr < IN_DB && b_irq) |=> a_busy);
  assert_busy_on_blocked_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (b_sel && b_we && b_addr < IN_DB && a_irq) |=> b_busy);
endmodule

bind doorbell_mailbox doorbell_mailbox_chk u_chk (.*);

// File: tb/doorbell_mailbox_test.sv
module doorbell_mailbox_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEEP = 32'h800F_3C7F;

  logic clk = 0, rst_n = 0;
  logic a_sel = 0, a_we = 0, b_sel = 0, b_we = 0;
  logic [5:0] a_addr = 0, b_addr = 0;
  logic [31:0] a_wdata = 0, b_wdata = 0, a_tx_data = 0, b_tx_data = 0;
  logic a_tx_valid = 0, a_tx_last = 0, b_tx_valid = 0, b_tx_last = 0;
  logic [31:0] a_rdata, b_rdata;
  logic a_busy, b_busy, a_irq, b_irq, a_tx_ready, b_tx_ready;
  int checks = 0, fails = 0;
  bit done = 0;

  doorbell_mailbox uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] expect_db(input logic [31:0] v);
    logic [31:0] r;
    r = v & KEEP;
    if (v[13:10] != 4'd1) r[19:16] = 4'd0;
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int side, input logic [5:0] ad, input logic [31:0] d, output bit bsy);
    @(negedge clk);
    if (side == 0) begin a_sel = 1; a_we = 1; a_addr = ad; a_wdata = d; end
    else begin b_sel = 1; b_we = 1; b_addr = ad; b_wdata = d; end
    @(negedge clk);
    a_sel = 0; a_we = 0; b_sel = 0; b_we = 0;
    bsy = (side == 0) ? a_busy : b_busy;
  endtask

  task automatic bus_rd(input int side, input logic [5:0] ad, output logic [31:0] d);
    @(negedge clk);
    if (side == 0) begin a_sel = 1; a_addr = ad; end
    else begin b_sel = 1; b_addr = ad; end
    #1;
    d = (side == 0) ? a_rdata : b_rdata;
    @(negedge clk);
    a_sel = 0; b_sel = 0;
  endtask

  task automatic beat(input int side, input logic [31:0] d, input logic last);
    bit rdy;
    @(negedge clk);
    if (side == 0) begin a_tx_valid = 1; a_tx_data = d; a_tx_last = last; end
    else begin b_tx_valid = 1; b_tx_data = d; b_tx_last = last; end
    forever begin
      rdy = (side == 0) ? a_tx_ready : b_tx_ready;
      @(posedge clk);
      @(negedge clk);
      if (rdy) break;
    end
    a_tx_valid = 0; b_tx_valid = 0; a_tx_last = 0; b_tx_last = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 a_irq", a_irq, 0);
    check("R1 b_irq", b_irq, 0);
    check("R1 a_busy", a_busy, 0);
    check("R1 tx_ready", a_tx_ready, 1);
    bus_rd(0, 32, v); check("R1 a in doorbell", v, 0);
    bus_rd(1, 33, v); check("R1 b out doorbell", v, 0);
    bus_rd(0, 0, v);  check("R1 a word0", v, 0);
  endtask

  task automatic t_basic;
    logic [31:0] v; bit bs;
    logic [31:0] d = 32'hFA35_2B8C;
    bus_wr(0, 0, 32'hA0A0_0001, bs);
    check("R2 write accepted no busy", bs, 0);
    bus_wr(0, 31, 32'hA0A0_001F, bs);
    check("R5 irq low before doorbell", b_irq, 0);
    bus_wr(0, 33, d, bs);
    check("R5 b_irq raised", b_irq, 1);
    check("R5 a_irq independent", a_irq, 0);
    bus_rd(1, 32, v); check("R3 R4 scrubbed doorbell", v, expect_db(d));
    bus_rd(0, 33, v); check("R2 outbound readback", v, expect_db(d));
    bus_rd(1, 0, v);  check("R5 word0", v, 32'hA0A0_0001);
    bus_rd(1, 31, v); check("R5 word31", v, 32'hA0A0_001F);
    bus_rd(1, 40, v); check("R2 unmapped reads 0", v, 0);
  endtask

  task automatic t_busy_clear;
    logic [31:0] v; bit bs;
    bus_wr(0, 0, 32'hDEAD_0000, bs);
    check("R7 busy on blocked word write", bs, 1);
    bus_wr(1, 32, 32'hFFFF_FFFF, bs);
    check("R6 bit31=1 write ignored", b_irq, 1);
    bus_rd(1, 32, v); check("R6 doorbell unchanged", v, expect_db(32'hFA35_2B8C));
    bus_wr(1, 32, 32'h0000_0000, bs);
    check("R6 clear drops irq", b_irq, 0);
    bus_rd(1, 32, v); check("R6 fields retained", v, expect_db(32'h7A35_2B8C));
    bus_rd(1, 0, v);  check("R7 dropped write not stored", v, 32'hA0A0_0001);
    bus_wr(0, 0, 32'h1234_5678, bs);
    check("R7 no busy when free", bs, 0);
    bus_rd(1, 0, v);  check("R7 write after free stored", v, 32'h1234_5678);
  endtask

  task automatic t_mgmt_b2a;
    logic [31:0] v; bit bs;
    bus_wr(1, 7, 32'hCAFE_0007, bs);
    bus_wr(1, 33, 32'h8009_0420, bs);
    check("R5 a_irq raised", a_irq, 1);
    check("R5 b_irq stays low", b_irq, 0);
    bus_rd(0, 32, v); check("R4 command kept for protocol 1", v, 32'h8009_0420);
    bus_rd(0, 7, v);  check("R5 b2a word7", v, 32'hCAFE_0007);
    bus_wr(0, 32, 32'h0, bs);
    check("R6 a clear", a_irq, 0);
  endtask

  task automatic t_stream;
    logic [31:0] v; bit bs;
    beat(0, 32'h1111_0000, 0);
    beat(0, 32'h1111_0001, 0);
    beat(0, 32'h8000_0408, 1);
    for (int i = 0; i < 4; i++) beat(0, 32'h2222_0000 + i, 0);
    idle(3);
    check("R8 tx_ready low when queue full", a_tx_ready, 0);
    check("R8 irq from stream", b_irq, 1);
    bus_rd(1, 32, v); check("R9 first fragment presented", v, 32'h8000_0408);
    bus_rd(1, 0, v);  check("R8 stream word0", v, 32'h1111_0000);
    bus_rd(1, 1, v);  check("R8 stream word1", v, 32'h1111_0001);
    bus_wr(0, 5, 32'h5555_5555, bs);
    check("R7 busy while queue pending", bs, 1);
    bus_wr(1, 32, 32'h0, bs);
    idle(6);
    check("R9 irq low until last beat", b_irq, 0);
    check("R8 tx_ready back", a_tx_ready, 1);
    beat(0, 32'h0000_0810, 1);
    idle(3);
    check("R9 second fragment irq", b_irq, 1);
    bus_rd(1, 32, v); check("R8 trigger forced on last beat", v, 32'h8000_0810);
    bus_rd(1, 0, v);  check("R9 second word0", v, 32'h2222_0000);
    bus_rd(1, 3, v);  check("R9 second word3", v, 32'h2222_0003);
    bus_rd(1, 5, v);  check("R7 busy write absent", v, 32'h0);
    bus_wr(1, 32, 32'h0, bs);
  endtask

  task automatic t_overflow;
    logic [31:0] v; bit bs;
    for (int i = 0; i < 33; i++) beat(0, 100 + i, 0);
    beat(0, 32'h8000_0004, 1);
    idle(6);
    check("R10 irq", b_irq, 1);
    bus_rd(1, 31, v); check("R10 word31 keeps 32nd value", v, 131);
    bus_rd(1, 0, v);  check("R10 word0", v, 100);
    bus_wr(1, 32, 32'h0, bs);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    t_reset;
    t_basic;
    t_busy_clear;
    t_mgmt_b2a;
    t_stream;
    t_overflow;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule